// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block turns the three-bit bus status code of a processor running with an external command generator into the strobes that memory and I/O devices need. The processor leaves the status lines at the passive code (all ones) between transfers. Moving to any other code starts a transfer. The block captures that code and runs a fixed sequence of phases: an address phase, a command-lead phase, a data phase, optional wait phases, and a final data phase. In each phase it drives the address latch enable, the data transceiver enable and direction, and one active-low command strobe.

The sequence does not depend on when the status lines change again. When the final phase ends, every strobe is released. A new transfer can only start after the status lines have shown the passive code again. The ready input stretches the data phase. Each clock in which ready is low at the close of the data phase, or of a wait phase, adds one more wait phase, and the strobes stay asserted throughout.

Top module: `bus_cmd_gen`

## Requirements
- R1: The status code captured at the start of a transfer selects one strobe. 000 selects interrupt acknowledge (`inta_no`), 001 I/O read (`ior_no`), 010 I/O write (`iow_no`), 100 and 101 memory read (`mrd_no`), and 110 memory write (`mwr_no`). At most one strobe is low at any time.
- R2: Code 011 (halt) runs the phase sequence but drives no strobe, no `ale_o` and no `den_o`.
- R3: A transfer starts only on a clock edge where the state machine is idle, `status_i` is not 111, and `status_i` was 111 at the previous edge. Any change from one non-passive code to another starts nothing, and so does a non-passive code that is present when reset is released.
- R4: `ale_o` is high for exactly one clock, in the first phase, for every code except 111 and 011.
- R5: For codes 000, 001, 100 and 101, `dt_tx_o` is low (receive) from the first phase through the final phase. For writes, for halt and while idle it is high (transmit).
- R6: Read-type strobes (interrupt acknowledge, I/O read, memory read) and `den_o` are active from the second phase through the final phase. Write strobes are active from the third phase through the final phase.
- R7: If `ready_i` is low at the edge that ends the third phase, or at the edge that ends a wait phase, one more wait phase follows. During that wait phase the strobes and `den_o` stay active. The final phase follows the first edge at which `ready_i` is high.
- R8: After the final phase all strobes are high, `den_o` is low and `dt_tx_o` is high. They stay that way until a new transfer starts.
- R9: An asynchronous low on `rst_ni` immediately forces every strobe high, `ale_o` and `den_o` low and `dt_tx_o` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| status_i | input | 3 | Bus status code from the processor; 111 means passive |
| ready_i | input | 1 | High when the addressed device can finish the transfer |
| ale_o | output | 1 | Address latch enable, high for one clock |
| den_o | output | 1 | Data transceiver enable, active high |
| dt_tx_o | output | 1 | Transceiver direction: 1 transmit, 0 receive |
| inta_no | output | 1 | Interrupt acknowledge strobe, active low |
| ior_no | output | 1 | I/O read strobe, active low |
| iow_no | output | 1 | I/O write strobe, active low |
| mrd_no | output | 1 | Memory read strobe, active low |
| mwr_no | output | 1 | Memory write strobe, active low |

## Verification
The block has no tunable parameters, so the bench builds it with the package constants as they are: a three-bit status code, five strobes and seven phases. This is enough to reach every one of the eight status codes, with zero, one and several wait phases. It also reaches the transitions that must not start a transfer: a non-passive code held through reset release, a code held after the final phase, and a direct change between two non-passive codes. Finally, it covers a reset that lands in the middle of a data phase.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;
  localparam int STAT_W  = 3;
  localparam int NUM_CMD = 5;

  // strobe index order, also used by the bench's port mapping
  localparam int CMD_INTA = 4;
  localparam int CMD_IOR  = 3;
  localparam int CMD_IOW  = 2;
  localparam int CMD_MRD  = 1;
  localparam int CMD_MWR  = 0;

  localparam logic [NUM_CMD-1:0] WR_CMDS = NUM_CMD'((1 << CMD_IOW) | (1 << CMD_MWR));

  typedef enum logic [STAT_W-1:0] {
    ST_INTA    = 3'b000,
    ST_IORD    = 3'b001,
    ST_IOWR    = 3'b010,
    ST_HALT    = 3'b011,
    ST_FETCH   = 3'b100,
    ST_MEMRD   = 3'b101,
    ST_MEMWR   = 3'b110,
    ST_PASSIVE = 3'b111
  } stat_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_T1, PH_T2, PH_T3, PH_TW, PH_T4, PH_END
  } phase_e;

  function automatic logic [NUM_CMD-1:0] cmd_sel(input logic [STAT_W-1:0] code);
    logic [NUM_CMD-1:0] s;
    s = '0;
    unique case (code)
      ST_INTA:            s[CMD_INTA] = 1'b1;
      ST_IORD:            s[CMD_IOR]  = 1'b1;
      ST_IOWR:            s[CMD_IOW]  = 1'b1;
      ST_FETCH, ST_MEMRD: s[CMD_MRD]  = 1'b1;
      ST_MEMWR:           s[CMD_MWR]  = 1'b1;
      default:            s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/bus_status_sampler.sv
module bus_status_sampler
  import bus_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] status_i,
  input  logic              load_i,
  output logic              armed_o,
  output logic [STAT_W-1:0] code_o
);
  logic              armed_q;
  logic [STAT_W-1:0] code_q;

  // armed only after passive was seen, so reset with a live code never starts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      code_q  <= ST_PASSIVE;
    end else begin
      armed_q <= (status_i == ST_PASSIVE);
      if (load_i) code_q <= status_i;
    end
  end

  assign armed_o = armed_q;
  assign code_o  = code_q;
endmodule

// File: rtl/bus_cycle_fsm.sv
module bus_cycle_fsm
  import bus_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] status_i,
  input  logic              ready_i,
  input  logic              armed_i,
  output logic              start_o,
  output phase_e            phase_o
);
  phase_e phase_q, phase_d;
  logic   passive;

  assign passive = (status_i == ST_PASSIVE);
  assign start_o = (phase_q == PH_IDLE) && armed_i && !passive;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (start_o) phase_d = PH_T1;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3:   phase_d = ready_i ? PH_T4 : PH_TW;
      PH_TW:   phase_d = ready_i ? PH_T4 : PH_TW;
      PH_T4:   phase_d = passive ? PH_IDLE : PH_END;
      PH_END:  phase_d = passive ? PH_IDLE : PH_END;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  // R3
  no_start_unarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !armed_i) |=> (phase_q == PH_IDLE));
  // R7
  wait_insert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_T3 || phase_q == PH_TW) && !ready_i) |=> (phase_q == PH_TW));
  // R7
  wait_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_T3 || phase_q == PH_TW) && ready_i) |=> (phase_q == PH_T4));
endmodule

// File: rtl/bus_cmd_decode.sv
module bus_cmd_decode
  import bus_cmd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  phase_e             phase_i,
  input  logic [STAT_W-1:0]  code_i,
  output logic [NUM_CMD-1:0] strobe_no,
  output logic               ale_o,
  output logic               den_o,
  output logic               dt_tx_o
);
  logic [NUM_CMD-1:0] sel;
  logic               busy, early, late, is_halt, is_rx;

  assign sel     = cmd_sel(code_i);
  assign is_halt = (code_i == ST_HALT);
  assign is_rx   = |(sel & ~WR_CMDS);
  assign busy    = (phase_i != PH_IDLE) && (phase_i != PH_END);
  assign late    = (phase_i == PH_T3) || (phase_i == PH_TW) || (phase_i == PH_T4);
  assign early   = late || (phase_i == PH_T2);

  for (genvar i = 0; i < NUM_CMD; i++) begin : g_strobe
    if (WR_CMDS[i]) begin : g_wr
      assign strobe_no[i] = !(sel[i] && late);
    end else begin : g_rd
      assign strobe_no[i] = !(sel[i] && early);
    end
  end

  assign ale_o   = (phase_i == PH_T1) && !is_halt && (code_i != ST_PASSIVE);
  assign den_o   = early && !is_halt;
  assign dt_tx_o = !(busy && is_rx);

  // R1
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~strobe_no));
  // R4
  ale_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o);
  // R6
  wr_late_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_no[CMD_IOW] || !strobe_no[CMD_MWR]) |-> $past(phase_i) != PH_T1);
  // R2
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != PH_IDLE && code_i == ST_HALT) |-> (&strobe_no && !ale_o && !den_o));
endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
  import bus_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] status_i,
  input  logic              ready_i,
  output logic              ale_o,
  output logic              den_o,
  output logic              dt_tx_o,
  output logic              inta_no,
  output logic              ior_no,
  output logic              iow_no,
  output logic              mrd_no,
  output logic              mwr_no
);
  logic               armed, start;
  logic [STAT_W-1:0]  code;
  phase_e             phase;
  logic [NUM_CMD-1:0] strobe_n;

  bus_status_sampler u_sampler (
    .clk_i, .rst_ni, .status_i,
    .load_i (start),
    .armed_o(armed),
    .code_o (code)
  );

  bus_cycle_fsm u_fsm (
    .clk_i, .rst_ni, .status_i, .ready_i,
    .armed_i(armed),
    .start_o(start),
    .phase_o(phase)
  );

  bus_cmd_decode u_decode (
    .clk_i, .rst_ni,
    .phase_i  (phase),
    .code_i   (code),
    .strobe_no(strobe_n),
    .ale_o, .den_o, .dt_tx_o
  );

  assign inta_no = strobe_n[CMD_INTA];
  assign ior_no  = strobe_n[CMD_IOR];
  assign iow_no  = strobe_n[CMD_IOW];
  assign mrd_no  = strobe_n[CMD_MRD];
  assign mwr_no  = strobe_n[CMD_MWR];

  // R5
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_IDLE && phase != PH_END && phase != PH_T1) |-> $stable(dt_tx_o));
  // R8
  end_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_END) |-> (&strobe_n && !den_o && dt_tx_o));
endmodule

// File: tb/bus_cmd_gen_bench.sv
module bus_cmd_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [2:0] status_i = 3'b111;
  logic       ready_i = 1'b1;
  logic       ale_o, den_o, dt_tx_o, inta_no, ior_no, iow_no, mrd_no, mwr_no;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  bus_cmd_gen u_bus_cmd_gen (.*);

  // strobe view {inta, ior, iow, mrd, mwr}, 1 = active
  logic [4:0] act;
  assign act = ~{inta_no, ior_no, iow_no, mrd_no, mwr_no};
  localparam logic [4:0] WR_MASK = 5'b00101;

  // entry: code[11:9] waits[8:7] mask[6:2] ale[1] rx[0]
  localparam int NV = 11;
  localparam logic [11:0] VEC [NV] = '{
    {3'b000, 2'd0, 5'b10000, 1'b1, 1'b1},
    {3'b001, 2'd0, 5'b01000, 1'b1, 1'b1},
    {3'b010, 2'd0, 5'b00100, 1'b1, 1'b0},
    {3'b011, 2'd0, 5'b00000, 1'b0, 1'b0},
    {3'b100, 2'd0, 5'b00010, 1'b1, 1'b1},
    {3'b101, 2'd0, 5'b00010, 1'b1, 1'b1},
    {3'b110, 2'd0, 5'b00001, 1'b1, 1'b0},
    {3'b101, 2'd1, 5'b00010, 1'b1, 1'b1},
    {3'b110, 2'd3, 5'b00001, 1'b1, 1'b0},
    {3'b001, 2'd2, 5'b01000, 1'b1, 1'b1},
    {3'b011, 2'd2, 5'b00000, 1'b0, 1'b0}
  };

  task automatic check(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, "strobes", {3'b0, act}, 8'h00);
    check(req, "den", {7'b0, den_o}, 8'h00);
    check(req, "ale", {7'b0, ale_o}, 8'h00);
    check(req, "dir", {7'b0, dt_tx_o}, 8'h01);
  endtask

  task automatic run_vec(input logic [11:0] v);
    logic [2:0] code = v[11:9];
    int         waits = int'(v[8:7]);
    logic [4:0] mask = v[6:2];
    logic       halt = (code == 3'b011);
    logic       dir = !v[0];
    @(negedge clk_i); status_i = code; ready_i = 1'b1;
    @(negedge clk_i); // T1
    check("R4", "ale in T1", {7'b0, ale_o}, {7'b0, v[1]});
    check("R6", "no strobe in T1", {3'b0, act}, 8'h00);
    check("R5", "dir in T1", {7'b0, dt_tx_o}, {7'b0, dir});
    @(negedge clk_i); // T2
    check("R4", "ale after T1", {7'b0, ale_o}, 8'h00);
    check("R6", "early strobes", {3'b0, act}, {3'b0, mask & ~WR_MASK});
    check("R2", "den in T2", {7'b0, den_o}, {7'b0, !halt});
    if (waits > 0) ready_i = 1'b0;
    @(negedge clk_i); // T3
    check("R1", "strobe select", {3'b0, act}, {3'b0, mask});
    for (int w = 0; w < waits; w++) begin
      @(negedge clk_i); // TW
      check("R7", "held in wait", {3'b0, act}, {3'b0, mask});
      check("R7", "den in wait", {7'b0, den_o}, {7'b0, !halt});
      if (w == waits - 1) ready_i = 1'b1;
    end
    @(negedge clk_i); // T4
    check("R6", "strobes in T4", {3'b0, act}, {3'b0, mask});
    check("R5", "dir in T4", {7'b0, dt_tx_o}, {7'b0, dir});
    status_i = 3'b111;
    @(negedge clk_i);
    check_idle("R8");
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    status_i = 3'b101;
    #1;
    check_idle("R9");
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // R3: live code at reset release starts nothing
    repeat (4) begin
      @(negedge clk_i);
      check("R3", "no start after reset", {2'b0, ale_o, act}, 8'h00);
    end
    status_i = 3'b111;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R8: status held after final phase, then direct code change (R3)
    @(negedge clk_i); status_i = 3'b101;
    repeat (4) @(negedge clk_i); // T1..T4
    check("R1", "mem read in T4", {3'b0, act}, 8'h02);
    repeat (3) begin
      @(negedge clk_i);
      check_idle("R8");
    end
    status_i = 3'b110;
    repeat (3) begin
      @(negedge clk_i);
      check("R3", "no restart without passive", {2'b0, ale_o, act}, 8'h00);
    end
    status_i = 3'b111;
    @(negedge clk_i);
    run_vec({3'b010, 2'd1, 5'b00100, 1'b1, 1'b0});

    // R9: reset in the data phase
    @(negedge clk_i); status_i = 3'b000;
    repeat (3) @(negedge clk_i);
    check("R1", "inta before reset", {3'b0, act}, 8'h10);
    rst_ni = 1'b0;
    #1;
    check_idle("R9");
    @(negedge clk_i);
    status_i = 3'b111;
    rst_ni = 1'b1;
    @(negedge clk_i);
    run_vec(VEC[0]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule